// File: doc/BRIEF.md
# Load-Store Register Datapath

This block is the execute datapath of a small load-store processor. One control word per clock drives it. The control word selects two registers to read and chooses the second ALU operand, which is either register B or a constant carried in the word. It also picks the ALU operation, and it decides whether the ALU result or the memory read data is written back to a destination register. A separate bit writes register B into data memory. Instruction fetch, decoding and the program counter sit outside the block and produce the control words.

The ALU sees only register contents and the constant. A value held in memory must therefore be loaded into a register before any arithmetic can use it. Memory is always addressed by register-read port A, so every load and store is register-indirect. An absolute address has to be placed in a register first, for example with a pass-constant operation. The read ports, the ALU result, the memory read data and the four status flags are all brought out, so the block can be observed cycle by cycle.

Top module: `rf_datapath`

## Requirements
- R1: While rst_n is low, and right after it, every one of the 8 registers reads as 0.
- R2: rd_a and rd_b show the registers chosen by rf_src_a and rf_src_b combinationally, in the same cycle the selects change.
- R3: On a rising clock edge with rf_we high, register rf_dst takes the write-back value. With rf_we low, no register changes.
- R4: When opb_const_sel is 1, the second ALU operand is const_word. When it is 0, the second operand is rd_b.
- R5: alu_fn codes: 0 A+B, 1 A-B, 2 A+1, 3 A&B, 4 A|B, 5 A^B, 6 ~A, 7 pass B. Codes 8 to 15 give a result of 0.
- R6: Flag definitions:
  - flag_n is result bit 15 and flag_z is high when the result is 0.
  - For add and increment, flag_c is the carry out. For subtract, flag_c is 1 when A >= B, unsigned (no borrow).
  - flag_v marks two's-complement overflow of add, subtract and increment.
  - Logic, pass and reserved codes clear both flag_v and flag_c.
- R7: With wb_from_mem = 1, the written-back value is mem_out. With wb_from_mem = 0, it is alu_out.
- R8: On a rising edge with mem_we high, the word at address rd_a[7:0] takes rd_b. mem_out shows the word at rd_a[7:0] combinationally, so the stored value is visible from the next cycle.
- R9: Only the low 8 bits of rd_a address the 256-word memory. Register values 1000 and 232 therefore select the same word.
- R10: The sequence below leaves 42 in M[1000] when that word starts at 41:
  - load R0 with 1000;
  - load R3 from (R0);
  - add the constant 1 to R3;
  - store R3 to (R0).

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the register file |
| rf_we | input | 1 | Register write enable |
| rf_dst | input | 3 | Destination register |
| rf_src_a | input | 3 | Register for read port A (also the memory address) |
| rf_src_b | input | 3 | Register for read port B (also the store data) |
| opb_const_sel | input | 1 | Second ALU operand: 1 selects constant, 0 selects rd_b |
| const_word | input | 16 | Constant operand from the control word |
| alu_fn | input | 4 | ALU function code |
| wb_from_mem | input | 1 | Write-back source: 1 selects memory, 0 selects ALU |
| mem_we | input | 1 | Memory write enable |
| rd_a | output | 16 | Read port A data |
| rd_b | output | 16 | Read port B data |
| alu_out | output | 16 | ALU result |
| mem_out | output | 16 | Memory word at rd_a[7:0] |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
A wrong register value shows on rd_a or rd_b in the first cycle that selects that register. Because the read ports are combinational, the error appears one edge after the faulty write. A corrupted memory word shows on mem_out as soon as port A points at its address. A bad operand mux or ALU function shows in the same cycle on alu_out and on the flags. The reference model is compared against every visible output on every control word, so each fault is caught within one cycle of first becoming observable.

// File: rtl/rf_datapath_pkg.sv
package rf_datapath_pkg;
    localparam int FN_W = 4;
    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_INC  = 4'd2,
        FN_AND  = 4'd3,
        FN_OR   = 4'd4,
        FN_XOR  = 4'd5,
        FN_NOT  = 4'd6,
        FN_PASS = 4'd7
    } alu_fn_e;
endpackage

// File: rtl/rf_regfile.sv
module rf_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_N  = 8,
    localparam int ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    typedef struct packed {
        logic [REG_N-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.regs[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_a = st_q.regs[raddr_a];
    assign rdata_b = st_q.regs[raddr_b];
endmodule

// File: rtl/rf_alu.sv
module rf_alu
    import rf_datapath_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [FN_W-1:0]   fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              v,
    output logic              c,
    output logic              n,
    output logic              z
);
    localparam int MSB = DATA_W - 1;
    logic [DATA_W:0] wide;

    always_comb begin
        wide = '0;
        res  = '0;
        v    = 1'b0;
        c    = 1'b0;
        case (fn)
            FN_ADD: begin
                wide = {1'b0, opa} + {1'b0, opb};
                res  = wide[MSB:0];
                c    = wide[DATA_W];
                v    = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            FN_SUB: begin
                wide = {1'b0, opa} + {1'b0, ~opb} + {{DATA_W{1'b0}}, 1'b1};
                res  = wide[MSB:0];
                c    = wide[DATA_W];
                v    = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            FN_INC: begin
                wide = {1'b0, opa} + {{DATA_W{1'b0}}, 1'b1};
                res  = wide[MSB:0];
                c    = wide[DATA_W];
                v    = !opa[MSB] && res[MSB];
            end
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            FN_NOT:  res = ~opa;
            FN_PASS: res = opb;
            default: res = '0;
        endcase
        n = res[MSB];
        z = (res == '0);
    end
endmodule

// File: rtl/rf_dataram.sv
module rf_dataram #(
    parameter int DATA_W = 16,
    parameter int MEM_N  = 256,
    localparam int AW = $clog2(MEM_N)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [MEM_N-1:0][DATA_W-1:0] words;
    } ram_state_t;

    ram_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.words[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.words[addr];
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
    import rf_datapath_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_N  = 8,
    parameter int MEM_N  = 256,
    localparam int RA_W  = $clog2(REG_N),
    localparam int MA_W  = $clog2(MEM_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_we,
    input  logic [RA_W-1:0]   rf_dst,
    input  logic [RA_W-1:0]   rf_src_a,
    input  logic [RA_W-1:0]   rf_src_b,
    input  logic              opb_const_sel,
    input  logic [DATA_W-1:0] const_word,
    input  logic [FN_W-1:0]   alu_fn,
    input  logic              wb_from_mem,
    input  logic              mem_we,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] alu_out,
    output logic [DATA_W-1:0] mem_out,
    output logic              flag_v,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_z
);
    logic [DATA_W-1:0] opb_sel;
    logic [DATA_W-1:0] wb_value;

    assign opb_sel  = opb_const_sel ? const_word : rd_b;
    assign wb_value = wb_from_mem ? mem_out : alu_out;

    rf_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_dst), .wdata(wb_value),
        .raddr_a(rf_src_a), .raddr_b(rf_src_b), .rdata_a(rd_a), .rdata_b(rd_b)
    );

    rf_alu #(.DATA_W(DATA_W)) i_alu (
        .fn(alu_fn), .opa(rd_a), .opb(opb_sel), .res(alu_out),
        .v(flag_v), .c(flag_c), .n(flag_n), .z(flag_z)
    );

    rf_dataram #(.DATA_W(DATA_W), .MEM_N(MEM_N)) i_ram (
        .clk(clk), .we(mem_we), .addr(rd_a[MA_W-1:0]), .wdata(rd_b), .rdata(mem_out)
    );
endmodule

// File: rtl/rf_datapath_chk.sv
module rf_datapath_chk
    import rf_datapath_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RA_W   = 3,
    parameter int MA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rf_we,
    input logic [RA_W-1:0]   rf_dst,
    input logic [RA_W-1:0]   rf_src_a,
    input logic [FN_W-1:0]   alu_fn,
    input logic              mem_we,
    input logic [DATA_W-1:0] rd_a,
    input logic [DATA_W-1:0] rd_b,
    input logic [DATA_W-1:0] mem_out,
    input logic [DATA_W-1:0] wb_value,
    input logic              flag_v,
    input logic              flag_c
);
    AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mem_we) && rd_a[MA_W-1:0] == $past(rd_a[MA_W-1:0]))
        |-> mem_out == $past(rd_b)); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rf_we) && rf_src_a == $past(rf_dst))
        |-> rd_a == $past(wb_value)); // R3

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rf_we) && rf_src_a == $past(rf_src_a))
        |-> rd_a == $past(rd_a)); // R3

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn >= FN_AND) |-> (!flag_v && !flag_c)); // R6
endmodule

bind rf_datapath rf_datapath_chk #(.DATA_W(DATA_W), .RA_W(RA_W), .MA_W(MA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_dst(rf_dst), .rf_src_a(rf_src_a),
    .alu_fn(alu_fn), .mem_we(mem_we), .rd_a(rd_a), .rd_b(rd_b), .mem_out(mem_out),
    .wb_value(wb_value), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/test_rf_datapath.sv
module test_rf_datapath;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic rf_we = 0, opb_const_sel = 0, wb_from_mem = 0, mem_we = 0;
    logic [2:0] rf_dst = 0, rf_src_a = 0, rf_src_b = 0;
    logic [15:0] const_word = 0;
    logic [3:0] alu_fn = 0;
    logic [15:0] rd_a, rd_b, alu_out, mem_out;
    logic flag_v, flag_c, flag_n, flag_z;

    int checks = 0, errors = 0;
    int regs_m [8];
    int mem_m [256];
    bit mem_ok [256];

    always #(CLK_P/2) clk = ~clk;

    rf_datapath i_rf_datapath (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_dst(rf_dst), .rf_src_a(rf_src_a),
        .rf_src_b(rf_src_b), .opb_const_sel(opb_const_sel), .const_word(const_word),
        .alu_fn(alu_fn), .wb_from_mem(wb_from_mem), .mem_we(mem_we), .rd_a(rd_a),
        .rd_b(rd_b), .alu_out(alu_out), .mem_out(mem_out), .flag_v(flag_v),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void alu_ref(int fn, int a, int b, output int r, output int v, output int c);
        int sa, sb, s;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (b >= 32768) ? b - 65536 : b;
        v = 0; c = 0;
        case (fn)
            0: begin r = (a + b) % 65536; c = (a + b) > 65535; s = sa + sb; v = (s > 32767 || s < -32768); end
            1: begin r = (a - b + 65536) % 65536; c = (a >= b); s = sa - sb; v = (s > 32767 || s < -32768); end
            2: begin r = (a + 1) % 65536; c = (a == 65535); v = (a == 32767); end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = 65535 - a;
            7: r = b;
            default: r = 0;
        endcase
    endfunction

    task automatic op(string tag, bit we, int dst, int sa, int sb, bit cs, int k, int fn, bit wm, bit mw);
        int ea, eb, bo, r, v, c, wb;
        rf_we = we; rf_dst = dst[2:0]; rf_src_a = sa[2:0]; rf_src_b = sb[2:0];
        opb_const_sel = cs; const_word = k[15:0]; alu_fn = fn[3:0];
        wb_from_mem = wm; mem_we = mw;
        #1;
        ea = regs_m[sa]; eb = regs_m[sb]; bo = cs ? k : eb;
        alu_ref(fn, ea, bo, r, v, c);
        check("R2", "rd_a", int'(rd_a), ea);
        check("R2", "rd_b", int'(rd_b), eb);
        check(tag, "alu_out", int'(alu_out), r);
        check("R6", "flag_v", int'(flag_v), v);
        check("R6", "flag_c", int'(flag_c), c);
        check("R6", "flag_n", int'(flag_n), (r >= 32768) ? 1 : 0);
        check("R6", "flag_z", int'(flag_z), (r == 0) ? 1 : 0);
        if (mem_ok[ea % 256]) check("R8", "mem_out", int'(mem_out), mem_m[ea % 256]);
        wb = wm ? mem_m[ea % 256] : r;
        @(posedge clk);
        if (we) regs_m[dst] = wb;
        if (mw) begin mem_m[ea % 256] = eb; mem_ok[ea % 256] = 1; end
        @(negedge clk);
        rf_we = 0; mem_we = 0;
    endtask

    task automatic peek(string tag, int sa, int exp_reg, bit chk_mem, int exp_mem);
        rf_src_a = sa[2:0]; alu_fn = 4'd7; opb_const_sel = 0;
        #1;
        check(tag, "reg via rd_a", int'(rd_a), exp_reg);
        if (chk_mem) check(tag, "mem_out", int'(mem_out), exp_mem);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        foreach (regs_m[i]) regs_m[i] = 0;
        foreach (mem_ok[i]) mem_ok[i] = 0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rf_src_a = i[2:0]; #1;
            check("R1", "reg in reset", int'(rd_a), 0);
        end
        rst_n = 1;
        @(negedge clk);
        peek("R1", 5, 0, 0, 0);

        // memory-increment program (R10), word preset to 41
        op("R4", 1, 0, 0, 0, 1, 1000, 7, 0, 0);   // R0 <- 1000
        op("R4", 1, 1, 0, 0, 1, 41, 7, 0, 0);     // R1 <- 41
        op("R5", 0, 0, 0, 1, 0, 0, 7, 0, 1);      // M[R0] <- R1
        peek("R8", 0, 1000, 1, 41);
        op("R5", 1, 3, 0, 0, 0, 0, 7, 1, 0);      // R3 <- M[R0]
        peek("R7", 3, 41, 0, 0);
        op("R4", 1, 3, 3, 0, 1, 1, 0, 0, 0);      // R3 <- R3 + 1
        op("R5", 0, 0, 0, 3, 0, 0, 7, 0, 1);      // M[R0] <- R3
        peek("R10", 0, 1000, 1, 42);

        // aliasing on low address bits
        op("R4", 1, 5, 0, 0, 1, 232, 7, 0, 0);
        op("R9", 1, 6, 5, 0, 0, 0, 7, 1, 0);
        peek("R9", 6, 42, 1, 0);
        peek("R9", 5, 232, 1, 42);

        // no write when rf_we low
        op("R4", 0, 1, 0, 0, 1, 16'h5555, 7, 0, 0);
        peek("R3", 1, 41, 0, 0);

        // ALU corners: load operands then sweep functions
        op("R4", 1, 2, 0, 0, 1, 16'h7FFF, 7, 0, 0);
        op("R4", 1, 4, 0, 0, 1, 16'h8000, 7, 0, 0);
        op("R4", 1, 7, 0, 0, 1, 16'hFFFF, 7, 0, 0);
        for (int fn = 0; fn < 16; fn++) begin
            op("R5", 0, 0, 2, 4, 0, 0, fn, 0, 0);
            op("R5", 0, 0, 7, 7, 0, 0, fn, 0, 0);
            op("R5", 0, 0, 4, 2, 0, 0, fn, 0, 0);
            op("R4", 0, 0, 2, 4, 1, 1, fn, 0, 0);
            op("R5", 0, 0, 7, 3, 0, 0, fn, 0, 0);
        end
        op("R6", 1, 1, 7, 0, 1, 1, 0, 0, 0);      // FFFF+1 -> 0, carry
        op("R6", 0, 0, 1, 2, 0, 0, 1, 0, 0);      // 0-7FFF borrow

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule